// File: doc/BRIEF.md
# Transmit and Receive Statistics Counters with Interrupt Status

This block keeps the traffic statistics of one network port. Ten saturating counters record sent frames and bytes on the transmit side, and received, dropped, CRC-errored, pause, multicast and broadcast frames and bytes on the receive side. Event strobes from the frame datapath drive them. A counter only advances while the enable of its direction is high. Each counter has a sticky overflow bit. Each direction also has a frame-done bit.

Status bits are write-1-to-clear. They can be masked from the interrupt, and software can force them through a mirror address. Reading the mirror address returns the live status. The interrupt output is the OR of every status bit whose mask bit is clear. A single-cycle read/write strobe port gives access to all registers, and its read data is combinational.

Top module: `mac_stats_regs`

## Requirements
- R1: After reset every counter, status bit and mask bit reads 0 and `irq_o` is low.
- R2: With `tx_en_i` high, each cycle with `tx_frame_i` high adds 1 to the sent-frame counter (address 0x08) and adds `tx_bytes_i` to the sent-byte counter (address 0x09).
- R3: With `rx_en_i` high, each cycle with `rx_frame_i` high updates the receive counters as follows. The frame counter (0x0A) always adds 1. The byte counter (0x0B) always adds `rx_bytes_i`, errored frames included. When `rx_drop_i` is high, the dropped-frame counter (0x0C) adds 1 and the dropped-byte counter (0x0D) adds `rx_bytes_i`. The CRC (0x0E), pause (0x0F), multicast (0x10) and broadcast (0x11) counters each add 1 when their flag is high.
- R4: While the enable of a direction is low, that direction's counters keep their value whatever the event inputs do.
- R5: A counter stops at 2^CNT_W-1 and never wraps, even when a byte increment would carry it past that value.
- R6: When an increment would carry a counter past its maximum, its overflow bit is set. The transmit status word is at 0x00: bit 1 is frame-count overflow and bit 2 is byte-count overflow. The receive status word is at 0x03: bits 1 to 8 belong to the counters at 0x0A to 0x11 in address order.
- R7: A read of a counter clears that counter's overflow bit.
- R8: Bit 0 of the transmit status is set by each counted sent frame. Bit 0 of the receive status is set by each counted received frame that does not have `rx_drop_i` high.
- R9: Writing 1 to a bit of a status word clears that bit. Writing 0 leaves it unchanged.
- R10: Writing 1 to a bit at the mirror address (0x02 for transmit, 0x05 for receive) sets the status bit in the same position. A read of the mirror address returns the status word.
- R11: The mask words are at 0x01 (transmit) and 0x04 (receive). `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R12: While a direction is disabled, none of its status bits can be set, not even by forcing. Bits already set stay set and keep driving `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit direction enable |
| rx_en_i | input | 1 | Receive direction enable |
| tx_frame_i | input | 1 | One frame sent in this cycle |
| tx_bytes_i | input | BYTE_W | Bytes of the sent frame (header, data, CRC, pad) |
| rx_frame_i | input | 1 | One frame received in this cycle |
| rx_bytes_i | input | BYTE_W | Bytes of the received frame |
| rx_drop_i | input | 1 | Received frame is dropped |
| rx_crc_err_i | input | 1 | Received frame has a CRC error |
| rx_pause_i | input | 1 | Received frame is a pause frame |
| rx_mcast_i | input | 1 | Received frame is multicast |
| rx_bcast_i | input | 1 | Received frame is broadcast |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that an event flag is meaningful only in a cycle where the matching frame strobe is high. They also assume that a byte count appears only alongside a frame strobe, and that one register access happens per cycle. The quiet-interrupt property is conditioned on the absence of register writes, because unmasking an existing bit legitimately raises `irq_o`.

The bench drives all inputs on the falling edge, holds every flag low outside a frame strobe, and never asserts read and write together. For the saturation cases it shrinks the counter width so that the limit can be reached with a short run of frames.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int ADDR_W  = 5;
  localparam int NUM_CNT = 10;
  localparam int NUM_TX  = 3;
  localparam int NUM_RX  = 9;

  localparam logic [ADDR_W-1:0] A_TX_STAT = 5'h00;
  localparam logic [ADDR_W-1:0] A_TX_MASK = 5'h01;
  localparam logic [ADDR_W-1:0] A_TX_MIR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_RX_STAT = 5'h03;
  localparam logic [ADDR_W-1:0] A_RX_MASK = 5'h04;
  localparam logic [ADDR_W-1:0] A_RX_MIR  = 5'h05;
  localparam logic [ADDR_W-1:0] A_CNT0    = 5'h08;

  // counter slots; slot order fixes the overflow bit positions
  localparam int C_TX_FRM = 0;
  localparam int C_TX_BYT = 1;
  localparam int C_RX_FRM = 2;
  localparam int C_RX_BYT = 3;
  localparam int C_RX_DFR = 4;
  localparam int C_RX_DBY = 5;
  localparam int C_RX_CRC = 6;
  localparam int C_RX_PAU = 7;
  localparam int C_RX_MC  = 8;
  localparam int C_RX_BC  = 9;
endpackage

// File: rtl/mstat_rst_sync.sv
module mstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mstat_sat_counter.sv
module mstat_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SUM_W-1:0] sum;
  logic             past_max;

  always_comb begin
    sum      = SUM_W'(cnt_q) + SUM_W'(inc_i);
    past_max = (sum > SUM_W'(CNT_MAX));
    cnt_n    = past_max ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = en_i & past_max;
endmodule

// File: rtl/mstat_status.sv
module mstat_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] force_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wd_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         pend_o
);
  logic [N-1:0] stat_q, stat_n;
  logic [N-1:0] mask_q;

  // a new setting event wins over a clear in the same cycle
  always_comb begin
    stat_n = (stat_q & ~clr_i) | ({N{en_i}} & (evt_i | force_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wd_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/mac_stats_regs.sv
module mac_stats_regs
  import mstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              tx_frame_i,
  input  logic [BYTE_W-1:0] tx_bytes_i,
  input  logic              rx_frame_i,
  input  logic [BYTE_W-1:0] rx_bytes_i,
  input  logic              rx_drop_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_pause_i,
  input  logic              rx_mcast_i,
  input  logic              rx_bcast_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic                             rst_sync_n;
  logic [NUM_CNT-1:0][BYTE_W-1:0]   inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt;
  logic [NUM_CNT-1:0]               cnt_ovf;
  logic [NUM_CNT-1:0]               rd_hit;
  logic [NUM_TX-1:0]                tx_stat, tx_mask, tx_evt, tx_force, tx_clr;
  logic [NUM_RX-1:0]                rx_stat, rx_mask, rx_evt, rx_force, rx_clr;
  logic                             tx_pend, rx_pend;
  logic                             unused_wdata;

  mstat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // increment of each counter slot in this cycle
  always_comb begin
    inc           = '0;
    inc[C_TX_FRM] = tx_frame_i ? ONE : '0;
    inc[C_TX_BYT] = tx_frame_i ? tx_bytes_i : '0;
    inc[C_RX_FRM] = rx_frame_i ? ONE : '0;
    inc[C_RX_BYT] = rx_frame_i ? rx_bytes_i : '0;
    inc[C_RX_DFR] = (rx_frame_i && rx_drop_i) ? ONE : '0;
    inc[C_RX_DBY] = (rx_frame_i && rx_drop_i) ? rx_bytes_i : '0;
    inc[C_RX_CRC] = (rx_frame_i && rx_crc_err_i) ? ONE : '0;
    inc[C_RX_PAU] = (rx_frame_i && rx_pause_i) ? ONE : '0;
    inc[C_RX_MC]  = (rx_frame_i && rx_mcast_i) ? ONE : '0;
    inc[C_RX_BC]  = (rx_frame_i && rx_bcast_i) ? ONE : '0;
  end

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      localparam bit IS_TX = (k <= C_TX_BYT);
      mstat_sat_counter #(
        .CNT_W (CNT_W),
        .INC_W (BYTE_W)
      ) u_cnt (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en_i  (IS_TX ? tx_en_i : rx_en_i),
        .inc_i (inc[k]),
        .cnt_o (cnt[k]),
        .ovf_o (cnt_ovf[k])
      );
      assign rd_hit[k] = reg_rd_i && (reg_addr_i == (A_CNT0 + ADDR_W'(k)));
    end
  endgenerate

  // status events, forcing and clearing
  always_comb begin
    tx_evt   = {cnt_ovf[C_TX_BYT:C_TX_FRM], tx_frame_i};
    rx_evt   = {cnt_ovf[C_RX_BC:C_RX_FRM], rx_frame_i & ~rx_drop_i};
    tx_force = (reg_wr_i && reg_addr_i == A_TX_MIR) ? reg_wdata_i[NUM_TX-1:0] : '0;
    rx_force = (reg_wr_i && reg_addr_i == A_RX_MIR) ? reg_wdata_i[NUM_RX-1:0] : '0;
    tx_clr   = {rd_hit[C_TX_BYT:C_TX_FRM], 1'b0};
    rx_clr   = {rd_hit[C_RX_BC:C_RX_FRM], 1'b0};
    if (reg_wr_i && reg_addr_i == A_TX_STAT) tx_clr = tx_clr | reg_wdata_i[NUM_TX-1:0];
    if (reg_wr_i && reg_addr_i == A_RX_STAT) rx_clr = rx_clr | reg_wdata_i[NUM_RX-1:0];
  end

  mstat_status #(.N(NUM_TX)) u_tx_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (tx_en_i),
    .evt_i     (tx_evt),
    .force_i   (tx_force),
    .clr_i     (tx_clr),
    .mask_we_i (reg_wr_i && reg_addr_i == A_TX_MASK),
    .mask_wd_i (reg_wdata_i[NUM_TX-1:0]),
    .stat_o    (tx_stat),
    .mask_o    (tx_mask),
    .pend_o    (tx_pend)
  );

  mstat_status #(.N(NUM_RX)) u_rx_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (rx_en_i),
    .evt_i     (rx_evt),
    .force_i   (rx_force),
    .clr_i     (rx_clr),
    .mask_we_i (reg_wr_i && reg_addr_i == A_RX_MASK),
    .mask_wd_i (reg_wdata_i[NUM_RX-1:0]),
    .stat_o    (rx_stat),
    .mask_o    (rx_mask),
    .pend_o    (rx_pend)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_TX_STAT, A_TX_MIR: reg_rdata_o = DATA_W'(tx_stat);
      A_TX_MASK:           reg_rdata_o = DATA_W'(tx_mask);
      A_RX_STAT, A_RX_MIR: reg_rdata_o = DATA_W'(rx_stat);
      A_RX_MASK:           reg_rdata_o = DATA_W'(rx_mask);
      default: begin
        for (int k = 0; k < NUM_CNT; k++) begin
          if (reg_addr_i == (A_CNT0 + ADDR_W'(k))) reg_rdata_o = DATA_W'(cnt[k]);
        end
      end
    endcase
  end

  assign irq_o        = tx_pend | rx_pend;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_RX];
endmodule

// File: rtl/mac_stats_regs_chk.sv
module mac_stats_regs_chk
  import mstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 14,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_sync_n,
  input logic                          tx_en_i,
  input logic                          rx_en_i,
  input logic                          tx_frame_i,
  input logic [BYTE_W-1:0]             tx_bytes_i,
  input logic                          reg_wr_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [DATA_W-1:0]             reg_wdata_i,
  input logic [DATA_W-1:0]             reg_rdata_o,
  input logic                          irq_o,
  input logic [NUM_TX-1:0]             tx_stat,
  input logic [NUM_RX-1:0]             rx_stat,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_tx_stall_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_en_i |=> ($stable(cnt[C_TX_FRM]) && $stable(cnt[C_TX_BYT])));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (cnt[C_TX_BYT] >= $past(cnt[C_TX_BYT])));

  assert_byte_ovf_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en_i && tx_frame_i && tx_bytes_i != '0 && cnt[C_TX_BYT] == CNT_MAX) |=> tx_stat[2]);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && reg_addr_i == A_TX_STAT && !tx_en_i)
      |=> ((tx_stat & $past(reg_wdata_i[NUM_TX-1:0])) == '0));

  assert_mirror_rd_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i == A_RX_MIR) |-> (reg_rdata_o[NUM_RX-1:0] == rx_stat));

  assert_quiet_irq_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_en_i && !rx_en_i && !irq_o && !reg_wr_i) |=> !irq_o);
endmodule

bind mac_stats_regs mac_stats_regs_chk #(
  .CNT_W  (CNT_W),
  .BYTE_W (BYTE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .tx_en_i     (tx_en_i),
  .rx_en_i     (rx_en_i),
  .tx_frame_i  (tx_frame_i),
  .tx_bytes_i  (tx_bytes_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .tx_stat     (tx_stat),
  .rx_stat     (rx_stat),
  .cnt         (cnt)
);

// File: tb/mac_stats_regs_tb_top.sv
module mac_stats_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 12;
  localparam int BYTE_W = 14;
  localparam int DATA_W = 32;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en, rx_en, tx_frame, rx_frame;
  logic [BYTE_W-1:0] tx_bytes, rx_bytes;
  logic rx_drop, rx_crc, rx_pause, rx_mc, rx_bc;
  logic reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_stats_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_frame_i(tx_frame), .tx_bytes_i(tx_bytes),
    .rx_frame_i(rx_frame), .rx_bytes_i(rx_bytes), .rx_drop_i(rx_drop),
    .rx_crc_err_i(rx_crc), .rx_pause_i(rx_pause), .rx_mcast_i(rx_mc),
    .rx_bcast_i(rx_bc), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {tx_en, rx_en, tx_frame, rx_frame, rx_drop, rx_crc, rx_pause, rx_mc, rx_bc} = '0;
    {reg_wr, reg_rd} = '0;
    tx_bytes = '0; rx_bytes = '0; reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tx_evt(input int b, input int n);
    @(negedge clk);
    tx_frame = 1'b1; tx_bytes = BYTE_W'(b);
    repeat (n) @(negedge clk);
    tx_frame = 1'b0; tx_bytes = '0;
  endtask

  task automatic rx_evt(input int b, input logic dr, input logic cr,
                        input logic pa, input logic mc, input logic bc);
    @(negedge clk);
    rx_frame = 1'b1; rx_bytes = BYTE_W'(b);
    {rx_drop, rx_crc, rx_pause, rx_mc, rx_bc} = {dr, cr, pa, mc, bc};
    @(negedge clk);
    rx_frame = 1'b0; rx_bytes = '0;
    {rx_drop, rx_crc, rx_pause, rx_mc, rx_bc} = '0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    do_reset();
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), d);
      check("R1 reset value", d, 0);
    end
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_tx_count();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_en = 1'b1;
    tx_evt(100, 1);
    tx_evt(60, 1);
    rd(5'h08, d); check("R2 tx frames", d, 2);
    rd(5'h09, d); check("R2 tx bytes", d, 160);
    rd(5'h00, d); check("R8 tx frame sent bit", d, 1);
    check("R11 irq unmasked", irq, 1);
  endtask

  task automatic t_rx_count();
    logic [DATA_W-1:0] d;
    do_reset();
    rx_en = 1'b1;
    rx_evt(64, 0, 0, 0, 1, 0);
    rx_evt(70, 1, 1, 0, 0, 0);
    rx_evt(80, 0, 0, 0, 0, 1);
    rx_evt(90, 1, 0, 1, 0, 0);
    rd(5'h0A, d); check("R3 rx frames", d, 4);
    rd(5'h0B, d); check("R3 rx bytes incl errored", d, 304);
    rd(5'h0C, d); check("R3 dropped frames", d, 2);
    rd(5'h0D, d); check("R3 dropped bytes", d, 160);
    rd(5'h0E, d); check("R3 crc frames", d, 1);
    rd(5'h0F, d); check("R3 pause frames", d, 1);
    rd(5'h10, d); check("R3 mcast frames", d, 1);
    rd(5'h11, d); check("R3 bcast frames", d, 1);
    rd(5'h03, d); check("R8 rx frame received bit", d, 1);
  endtask

  task automatic t_rx_drop_only();
    logic [DATA_W-1:0] d;
    do_reset();
    rx_en = 1'b1;
    rx_evt(64, 1, 0, 0, 0, 0);
    rd(5'h03, d); check("R8 dropped frame leaves bit0", d, 0);
  endtask

  task automatic t_stall();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_evt(200, 3);
    rx_evt(64, 1, 1, 1, 1, 1);
    rd(5'h08, d); check("R4 tx frames stalled", d, 0);
    rd(5'h09, d); check("R4 tx bytes stalled", d, 0);
    rd(5'h0A, d); check("R4 rx frames stalled", d, 0);
    rd(5'h0D, d); check("R4 rx drop bytes stalled", d, 0);
    rd(5'h00, d); check("R12 tx status not set while off", d, 0);
    check("R12 irq low while off", irq, 0);
  endtask

  task automatic t_w1c_mirror();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_en = 1'b1; rx_en = 1'b1;
    tx_evt(10, 1);
    wr(5'h00, 32'h0); rd(5'h00, d); check("R9 write 0 keeps", d, 1);
    wr(5'h00, 32'h1); rd(5'h00, d); check("R9 write 1 clears", d, 0);
    check("R9 irq after clear", irq, 0);
    wr(5'h02, 32'h6); rd(5'h00, d); check("R10 tx force", d, 6);
    rd(5'h02, d); check("R10 tx mirror reads status", d, 6);
    wr(5'h00, 32'h2); rd(5'h02, d); check("R10 clear via status", d, 4);
    wr(5'h05, 32'h1FF); rd(5'h03, d); check("R10 rx force all", d, 32'h1FF);
    rd(5'h05, d); check("R10 rx mirror reads status", d, 32'h1FF);
  endtask

  task automatic t_mask();
    do_reset();
    tx_en = 1'b1; rx_en = 1'b1;
    wr(5'h01, 32'h7); wr(5'h04, 32'h1FF);
    wr(5'h02, 32'h7); wr(5'h05, 32'h1FF);
    check("R11 all masked irq low", irq, 0);
    wr(5'h04, 32'h0FF);
    check("R11 rx bit8 unmasked irq high", irq, 1);
    wr(5'h03, 32'h100);
    check("R11 irq low after clear", irq, 0);
  endtask

  task automatic t_disabled();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_en = 1'b1;
    tx_evt(5, 1);
    tx_en = 1'b0;
    wr(5'h02, 32'h6);
    rd(5'h00, d); check("R12 force ignored while off", d, 1);
    check("R12 existing irq stays", irq, 1);
    tx_evt(5, 1);
    rd(5'h08, d); check("R12 R4 counter held while off", d, 1);
  endtask

  task automatic t_saturate();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_en = 1'b1;
    tx_evt(3000, 1);
    rd(5'h00, d); check("R6 no overflow below max", d, 1);
    tx_evt(3000, 1);
    rd(5'h09, d); check("R5 byte counter saturates", d, MAXV);
    rd(5'h00, d); check("R6 R7 byte ovf cleared by read", d, 1);
    tx_evt(0, MAXV - 2);
    rd(5'h08, d); check("R5 frame counter at max", d, MAXV);
    rd(5'h00, d); check("R6 no frame ovf at max", d, 1);
    tx_evt(0, 1);
    rd(5'h00, d); check("R6 frame ovf set", d, 3);
    rd(5'h08, d); check("R5 frame counter stays", d, MAXV);
    rd(5'h00, d); check("R7 frame ovf cleared by read", d, 1);
  endtask

  task automatic t_sat_ovf_read_order();
    logic [DATA_W-1:0] d;
    do_reset();
    tx_en = 1'b1;
    tx_evt(4000, 1);
    tx_evt(4000, 1);
    rd(5'h00, d); check("R6 byte ovf bit2", d, 5);
  endtask

  initial begin
    t_reset();
    t_tx_count();
    t_rx_count();
    t_rx_drop_only();
    t_stall();
    t_w1c_mirror();
    t_mask();
    t_disabled();
    t_saturate();
    t_sat_ovf_read_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule